// File: doc/BRIEF.md
# SR-IOV Function Number Decoder

This block turns the 8-bit function number taken from a routing ID into a function identity. The identity is either a physical function (PF) with its index, or a virtual function (VF) with its parent PF index and its position among that PF's VFs. Numbers that name no live function are flagged as unsupported. A request strobe marks the cycles that carry a lookup. The answer appears one clock later, held in a registered result state.

Two numbering layouts are supported, chosen by `ari_en`.

- **Wide layout (`ari_en` = 1):** the low numbers are PFs, and a reserved gap runs up to the midpoint of the number space. VFs sit in the upper half. The VFs of each PF are placed by that PF's own first-VF offset, its stride and its enabled-VF count.
- **Compact layout (`ari_en` = 0):** only eight numbers exist. Number 0 is the single PF, and every other number is a VF of that PF.

The result state register holds one of four states, and it is reloaded on every clock:

| State | Meaning |
|-------|---------|
| `FN_NONE` | No request was made in the previous cycle. |
| `FN_PF` | The number resolved to a PF. |
| `FN_VF` | The number resolved to a VF. |
| `FN_UNSUP` | The number is reserved, out of range, or belongs to a disabled VF. |

Transitions:

- Any state goes to `FN_NONE` when `fn_req` is low.
- Otherwise any state goes to `FN_PF`, `FN_VF` or `FN_UNSUP`, according to the decode of the present inputs.
- Reset forces `FN_NONE`.

Top module: `fn_decoder`

## Requirements
- R1: While reset is asserted, `hit_valid`, `hit_unsup`, `hit_is_vf`, `hit_pf` and `hit_vf` are all 0, even with `fn_req` high.
- R2: A request in one cycle gives exactly one of `hit_valid` or `hit_unsup` high in the next cycle. A cycle without a request gives both low in the next cycle.
- R3: In the wide layout, a number below NUM_PF decodes as a PF: `hit_valid`=1, `hit_is_vf`=0, and `hit_pf` equals the number.
- R4: In the wide layout, numbers from NUM_PF up to 127 are reserved and decode as unsupported.
- R5: In the wide layout, VF n of PF p sits at number p + offset[p] + n × stride[p], with the sum taken without wrap. It decodes with `hit_valid`=1, `hit_is_vf`=1, `hit_pf`=p and `hit_vf`=n, when n < num_vfs[p] and n < MAX_VF. A stride of 0 places only VF 0.
- R6: In the wide layout, a number of 128 or more that matches no enabled VF decodes as unsupported. This includes positions at or beyond num_vfs[p].
- R7: When VF ranges overlap, the lowest-numbered PF wins, and within that PF the lowest VF index wins.
- R8: In the compact layout, number 0 is PF 0. Number k from 1 to 7 is VF k-1 of PF 0 when k-1 < num_vfs[0]; otherwise it is unsupported.
- R9: In the compact layout, numbers of 8 or more decode as unsupported.
- R10: When the VF enable bit of a PF (bit p of `vf_en`) is 0, none of its VF numbers decode as valid. In the compact layout, bit 0 governs numbers 1 to 7.
- R11: The index outputs not used by a result are 0: both indices are 0 on unsupported or idle results, and `hit_vf` is 0 on a PF result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fn_req | input | 1 | A lookup is presented this cycle |
| fn_num | input | FN_W | Function number to decode |
| ari_en | input | 1 | 1 selects the wide layout, 0 the compact layout |
| vf_en | input | NUM_PF | Per-PF VF enable bits |
| num_vfs | input | NUM_PF*FIELD_W | Per-PF enabled VF count; PF p occupies bits [p*FIELD_W +: FIELD_W] |
| vf_offset | input | NUM_PF*FIELD_W | Per-PF offset of the first VF, same packing |
| vf_stride | input | NUM_PF*FIELD_W | Per-PF spacing between VFs, same packing |
| hit_valid | output | 1 | Previous request resolved to a live function |
| hit_is_vf | output | 1 | The resolved function is a VF |
| hit_pf | output | PF_W | PF index, or parent PF index of a VF |
| hit_vf | output | VF_IDX_W | VF position within its parent PF |
| hit_unsup | output | 1 | Previous request named no live function |

## Verification
The assertions take for granted that every input is a known value on each sampled edge. They also assume that the configuration inputs (`ari_en`, `vf_en`, the counts, offsets and strides) describe the layout in force for the request sampled on that edge. The properties tie each result only to the number and mode of the cycle before.

The stimulus keeps within this in two ways:

- It changes configuration only in cycles that carry no request.
- It chooses offsets and strides whose VF positions stay inside the 8-bit space, except where overlap or out-of-range behaviour is the point of the test.

// File: rtl/fnd_pkg.sv
package fnd_pkg;

    // Registered result state of one lookup
    typedef enum logic [1:0] {
        FN_NONE  = 2'd0,
        FN_PF    = 2'd1,
        FN_VF    = 2'd2,
        FN_UNSUP = 2'd3
    } fn_kind_e;

endpackage

// File: rtl/fnd_vf_locator.sv
// Finds which VF of one PF a function number names, by walking
// the VF positions with a running sum of the stride.
module fnd_vf_locator #(
    parameter int FN_W     = 8,
    parameter int FIELD_W  = 16,
    parameter int MAX_VF   = 128,
    parameter int VF_IDX_W = 7,
    parameter int PF_NUM   = 0
) (
    input  logic [FN_W-1:0]     fn,
    input  logic                vf_on,
    input  logic [FIELD_W-1:0]  vf_count,
    input  logic [FIELD_W-1:0]  first_off,
    input  logic [FIELD_W-1:0]  step,
    output logic                hit,
    output logic [VF_IDX_W-1:0] idx
);

    localparam int SUM_W = FIELD_W + $clog2(MAX_VF) + 2;

    logic [SUM_W-1:0] pos;

    always_comb begin
        hit = 1'b0;
        idx = '0;
        pos = SUM_W'(PF_NUM) + SUM_W'(first_off);
        for (int n = 0; n < MAX_VF; n++) begin
            if (!hit && vf_on && (SUM_W'(n) < SUM_W'(vf_count))
                    && (pos == SUM_W'(fn))) begin
                hit = 1'b1;
                idx = VF_IDX_W'(n);
            end
            pos = pos + SUM_W'(step);
        end
    end

endmodule

// File: rtl/fnd_legacy_map.sv
// Compact layout: number 0 is the PF, numbers 1..LEG_FN-1 are VFs.
module fnd_legacy_map
    import fnd_pkg::*;
#(
    parameter int FN_W     = 8,
    parameter int FIELD_W  = 16,
    parameter int VF_IDX_W = 7,
    parameter int LEG_FN   = 8
) (
    input  logic [FN_W-1:0]     fn,
    input  logic                vf_on,
    input  logic [FIELD_W-1:0]  vf_count,
    output fn_kind_e            kind,
    output logic [VF_IDX_W-1:0] idx
);

    logic [FIELD_W-1:0] pos;

    always_comb begin
        kind = FN_UNSUP;
        idx  = '0;
        pos  = FIELD_W'(fn) - FIELD_W'(1);
        if (fn == '0) begin
            kind = FN_PF;
        end else if (fn < FN_W'(LEG_FN)) begin
            if (vf_on && (pos < vf_count)) begin
                kind = FN_VF;
                idx  = VF_IDX_W'(pos);
            end
        end
    end

endmodule

// File: rtl/fn_decoder.sv
module fn_decoder
    import fnd_pkg::*;
#(
    parameter int FN_W    = 8,
    parameter int NUM_PF  = 2,
    parameter int FIELD_W = 16,
    parameter int MAX_VF  = 128,
    parameter int LEG_FN  = 8,
    localparam int PF_W     = (NUM_PF > 1) ? $clog2(NUM_PF) : 1,
    localparam int VF_IDX_W = (MAX_VF > 1) ? $clog2(MAX_VF) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fn_req,
    input  logic [FN_W-1:0]             fn_num,
    input  logic                        ari_en,
    input  logic [NUM_PF-1:0]           vf_en,
    input  logic [NUM_PF*FIELD_W-1:0]   num_vfs,
    input  logic [NUM_PF*FIELD_W-1:0]   vf_offset,
    input  logic [NUM_PF*FIELD_W-1:0]   vf_stride,
    output logic                        hit_valid,
    output logic                        hit_is_vf,
    output logic [PF_W-1:0]             hit_pf,
    output logic [VF_IDX_W-1:0]         hit_vf,
    output logic                        hit_unsup
);

    localparam logic [FN_W-1:0] PF_LIMIT = FN_W'(NUM_PF);
    localparam logic [FN_W-1:0] VF_BASE  = FN_W'(1 << (FN_W - 1));

    logic [NUM_PF-1:0]   loc_hit;
    logic [VF_IDX_W-1:0] loc_idx [NUM_PF];

    fn_kind_e            leg_kind;
    logic [VF_IDX_W-1:0] leg_idx;

    fn_kind_e            kind_d, kind_q;
    logic [PF_W-1:0]     pf_d, pf_q;
    logic [VF_IDX_W-1:0] vf_d, vf_q;

    // One VF locator per PF for the wide layout
    for (genvar p = 0; p < NUM_PF; p++) begin : g_pf
        fnd_vf_locator #(
            .FN_W     (FN_W),
            .FIELD_W  (FIELD_W),
            .MAX_VF   (MAX_VF),
            .VF_IDX_W (VF_IDX_W),
            .PF_NUM   (p)
        ) i_loc (
            .fn        (fn_num),
            .vf_on     (vf_en[p]),
            .vf_count  (num_vfs[p*FIELD_W +: FIELD_W]),
            .first_off (vf_offset[p*FIELD_W +: FIELD_W]),
            .step      (vf_stride[p*FIELD_W +: FIELD_W]),
            .hit       (loc_hit[p]),
            .idx       (loc_idx[p])
        );
    end

    fnd_legacy_map #(
        .FN_W     (FN_W),
        .FIELD_W  (FIELD_W),
        .VF_IDX_W (VF_IDX_W),
        .LEG_FN   (LEG_FN)
    ) i_leg (
        .fn       (fn_num),
        .vf_on    (vf_en[0]),
        .vf_count (num_vfs[FIELD_W-1:0]),
        .kind     (leg_kind),
        .idx      (leg_idx)
    );

    // Next result state
    always_comb begin
        kind_d = FN_NONE;
        pf_d   = '0;
        vf_d   = '0;
        if (fn_req) begin
            if (ari_en) begin
                if (fn_num < PF_LIMIT) begin
                    kind_d = FN_PF;
                    pf_d   = PF_W'(fn_num);
                end else if (fn_num < VF_BASE) begin
                    kind_d = FN_UNSUP;
                end else begin
                    kind_d = FN_UNSUP;
                    // Walk downwards so the lowest PF is applied last
                    for (int p = NUM_PF - 1; p >= 0; p--) begin
                        if (loc_hit[p]) begin
                            kind_d = FN_VF;
                            pf_d   = PF_W'(p);
                            vf_d   = loc_idx[p];
                        end
                    end
                end
            end else begin
                kind_d = leg_kind;
                vf_d   = leg_idx;
            end
        end
    end

    // Result state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= FN_NONE;
            pf_q   <= '0;
            vf_q   <= '0;
        end else begin
            kind_q <= kind_d;
            pf_q   <= pf_d;
            vf_q   <= vf_d;
        end
    end

    // Outputs from the result state
    always_comb begin
        hit_valid = 1'b0;
        hit_is_vf = 1'b0;
        hit_unsup = 1'b0;
        hit_pf    = '0;
        hit_vf    = '0;
        unique case (kind_q)
            FN_NONE: begin
            end
            FN_PF: begin
                hit_valid = 1'b1;
                hit_pf    = pf_q;
            end
            FN_VF: begin
                hit_valid = 1'b1;
                hit_is_vf = 1'b1;
                hit_pf    = pf_q;
                hit_vf    = vf_q;
            end
            FN_UNSUP: begin
                hit_unsup = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/fnd_checker.sv
module fnd_checker #(
    parameter int FN_W     = 8,
    parameter int NUM_PF   = 2,
    parameter int PF_W     = 1,
    parameter int VF_IDX_W = 7,
    parameter int LEG_FN   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                fn_req,
    input logic [FN_W-1:0]     fn_num,
    input logic                ari_en,
    input logic [NUM_PF-1:0]   vf_en,
    input logic                hit_valid,
    input logic                hit_is_vf,
    input logic [PF_W-1:0]     hit_pf,
    input logic [VF_IDX_W-1:0] hit_vf,
    input logic                hit_unsup
);

    localparam logic [FN_W-1:0] PF_LIMIT = FN_W'(NUM_PF);
    localparam logic [FN_W-1:0] VF_BASE  = FN_W'(1 << (FN_W - 1));
    localparam logic [FN_W-1:0] LEG_TOP  = FN_W'(LEG_FN);

    p_one_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fn_req |=> (hit_valid ^ hit_unsup));

    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fn_req |=> (!hit_valid && !hit_unsup));

    p_pf_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_req && ari_en && fn_num < PF_LIMIT)
        |=> (hit_valid && !hit_is_vf && 32'(hit_pf) == 32'($past(fn_num))));

    p_reserved_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_req && ari_en && fn_num >= PF_LIMIT && fn_num < VF_BASE) |=> hit_unsup);

    p_compact_vf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_req && !ari_en && fn_num != '0 && fn_num < LEG_TOP)
        |=> (hit_unsup || (hit_is_vf && hit_pf == '0
             && 32'(hit_vf) == 32'($past(fn_num)) - 1)));

    p_compact_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_req && !ari_en && fn_num >= LEG_TOP) |=> hit_unsup);

    p_vf_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_req && vf_en == '0
         && ((ari_en && fn_num >= PF_LIMIT) || (!ari_en && fn_num != '0)))
        |=> hit_unsup);

    p_unsup_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit_unsup |-> (hit_pf == '0 && hit_vf == '0 && !hit_is_vf));

    p_pf_novf_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !hit_is_vf) |-> hit_vf == '0);

endmodule

bind fn_decoder fnd_checker #(
    .FN_W     (FN_W),
    .NUM_PF   (NUM_PF),
    .PF_W     (PF_W),
    .VF_IDX_W (VF_IDX_W),
    .LEG_FN   (LEG_FN)
) i_chk (.*);

// File: tb/test_fn_decoder.sv
`timescale 1ns/100ps
module test_fn_decoder;

    localparam int FN_W = 8, NUM_PF = 2, FIELD_W = 16, MAX_VF = 128;
    localparam int PF_W = 1, VF_IDX_W = 7;

    typedef struct {
        logic  valid;
        logic  unsup;
        logic  is_vf;
        int    pf;
        int    vf;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fn_req = 1'b0;
    logic [FN_W-1:0] fn_num = '0;
    logic ari_en = 1'b1;
    logic [NUM_PF-1:0] vf_en = '1;
    logic [FIELD_W-1:0] nvf [NUM_PF];
    logic [FIELD_W-1:0] off [NUM_PF];
    logic [FIELD_W-1:0] stp [NUM_PF];

    logic hit_valid, hit_is_vf, hit_unsup;
    logic [PF_W-1:0] hit_pf;
    logic [VF_IDX_W-1:0] hit_vf;

    int tests = 0, fails = 0;
    bit done = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    fn_decoder i_fn_decoder (
        .clk(clk), .rst_n(rst_n), .fn_req(fn_req), .fn_num(fn_num),
        .ari_en(ari_en), .vf_en(vf_en),
        .num_vfs({nvf[1], nvf[0]}),
        .vf_offset({off[1], off[0]}),
        .vf_stride({stp[1], stp[0]}),
        .hit_valid(hit_valid), .hit_is_vf(hit_is_vf), .hit_pf(hit_pf),
        .hit_vf(hit_vf), .hit_unsup(hit_unsup)
    );

    // Reference model written from the requirements
    function automatic exp_t model(int f, string tag);
        exp_t e;
        e.valid = 0; e.unsup = 1; e.is_vf = 0; e.pf = 0; e.vf = 0; e.tag = tag;
        if (!ari_en) begin
            if (f == 0) begin
                e.valid = 1; e.unsup = 0;
            end else if (f < 8 && vf_en[0] && (f - 1) < int'(nvf[0])) begin
                e.valid = 1; e.unsup = 0; e.is_vf = 1; e.vf = f - 1;
            end
        end else if (f < NUM_PF) begin
            e.valid = 1; e.unsup = 0; e.pf = f;
        end else if (f >= 128) begin
            for (int p = 0; p < NUM_PF; p++) begin
                int base, rel, n;
                bit ok;
                base = p + int'(off[p]);
                ok = 0; n = 0;
                if (vf_en[p] && f >= base) begin
                    rel = f - base;
                    if (stp[p] == 0) begin
                        ok = (rel == 0);
                    end else begin
                        ok = (rel % int'(stp[p])) == 0;
                        n  = rel / int'(stp[p]);
                    end
                end
                if (ok && n < int'(nvf[p]) && n < MAX_VF && e.unsup) begin
                    e.valid = 1; e.unsup = 0; e.is_vf = 1; e.pf = p; e.vf = n;
                end
            end
        end
        return e;
    endfunction

    task automatic send(int f, string tag);
        @(negedge clk);
        fn_req = 1'b1;
        fn_num = FN_W'(f);
        q.push_back(model(f, tag));
    endtask

    // Idle cycle; configuration may be changed right after it returns
    task automatic park();
        exp_t e;
        @(negedge clk);
        fn_req = 1'b0;
        e.valid = 0; e.unsup = 0; e.is_vf = 0; e.pf = 0; e.vf = 0; e.tag = "R2 R11";
        q.push_back(e);
    endtask

    // Monitor: one expected item per clock, compared just after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                tests++;
                if (hit_valid !== e.valid || hit_unsup !== e.unsup ||
                    hit_is_vf !== e.is_vf || int'(hit_pf) != e.pf ||
                    int'(hit_vf) != e.vf) begin
                    fails++;
                    $display("FAIL %s: got v=%b u=%b vf=%b pf=%0d idx=%0d, expected v=%b u=%b vf=%b pf=%0d idx=%0d",
                             e.tag, hit_valid, hit_unsup, hit_is_vf, hit_pf, hit_vf,
                             e.valid, e.unsup, e.is_vf, e.pf, e.vf);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        nvf[0] = 16'd4;  off[0] = 16'd128; stp[0] = 16'd2;
        nvf[1] = 16'd3;  off[1] = 16'd128; stp[1] = 16'd2;

        // R1: outputs stay low in reset even with a request present
        fn_req = 1'b1;
        repeat (3) @(negedge clk);
        tests++;
        if (hit_valid || hit_unsup || hit_is_vf || hit_pf != 0 || hit_vf != 0) begin
            fails++;
            $display("FAIL R1: got v=%b u=%b, expected all zero", hit_valid, hit_unsup);
        end
        fn_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Wide layout: PF0 VFs at 128,130,132,134; PF1 VFs at 129,131,133
        park();
        send(0,   "R3 R11");
        send(1,   "R3 R11");
        send(2,   "R4 R11");
        send(127, "R4");
        park();
        send(128, "R5");
        send(130, "R5");
        send(134, "R5");
        send(136, "R6 R11");
        send(129, "R5");
        send(133, "R5");
        send(135, "R6");
        send(255, "R6");
        send(131, "R2 R5");

        // Stride 0 keeps only VF 0
        park();
        stp[0] = 16'd0; nvf[0] = 16'd5;
        send(128, "R5");
        send(130, "R6");

        // Overlapping ranges: PF1 moved onto PF0's positions
        park();
        stp[0] = 16'd2; nvf[0] = 16'd4; off[1] = 16'd127;
        send(128, "R7");
        send(132, "R7");
        park();
        vf_en = 2'b10;
        send(128, "R10 R7");
        send(130, "R10 R7");
        send(134, "R10 R6");

        // Wide stride reaching the top of the space
        park();
        vf_en = 2'b11; off[0] = 16'd128; stp[0] = 16'd40; off[1] = 16'd128;
        send(248, "R5");
        send(168, "R5");
        send(169, "R6");

        // All VFs disabled
        park();
        vf_en = 2'b00;
        send(128, "R10");
        send(129, "R10");
        send(0,   "R10 R3");

        // Compact layout
        park();
        ari_en = 1'b0; vf_en = 2'b01; nvf[0] = 16'd3;
        send(0, "R8 R11");
        send(1, "R8");
        send(3, "R8");
        send(4, "R8");
        send(7, "R8");
        park();
        nvf[0] = 16'd7;
        send(7,   "R8");
        send(6,   "R8");
        send(8,   "R9");
        send(200, "R9");
        park();
        vf_en = 2'b10;
        send(1, "R10");
        send(0, "R10 R8");
        park();
        park();
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule